// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block cleans up one general-purpose input before the pin-status bit and the interrupt logic use it. The raw pin first passes through a two-flop synchronizer. A filter then decides when the clean level may follow the synchronized level. Time is measured in ticks of a slow reference clock. The tick arrives as a one-cycle enable in the system clock domain.

The configuration inputs are held static. They give a 4-bit window count, a two-bit unit select made of a "large" bit and a "unit" bit, and a two-bit filter mode. The window length is the count multiplied by the unit. The filter can act in both directions, in one direction only, or not at all. A one-sided filter suits level-sensitive interrupts. For an active-high level, short low-going dips stay visible and only rises must prove themselves. For an active-low level it is the reverse. Every accepted change of the clean level comes with a one-cycle pulse that names its direction.

Top module: `dbf_debounce`

## Requirements
- R1: While `rst` is high and after it is released, `level_out`, `rise_pulse` and `fall_pulse` are 0 until the input gives cause.
- R2: `pin_in` is synchronized by two flops. In mode 0 (bypass) `level_out` follows `pin_in` on the third rising clock edge after the input is sampled, and a one-cycle input pulse still passes.
- R3: The unit select {`cfg_large`,`cfg_unit`} sets the unit length in reference ticks: 00 gives 2, 01 gives 8, 10 gives 512 and 11 gives 2048.
- R4: The window is `cfg_count` units long. A count of 0 in a filtering mode counts as 1 unit.
- R5: In mode 3 a change in either direction is accepted only after the synchronized input has held the new level for the full window. A shorter pulse never reaches `level_out`.
- R6: In mode 1, rises are filtered and falls are accepted at once, so a short low-going dip appears on `level_out`.
- R7: In mode 2, falls are filtered and rises are accepted at once, so a short high-going spike appears on `level_out`.
- R8: If the synchronized input returns to the current output level during a window, the window is discarded. A later change starts a full new window.
- R9: Any change of the configuration inputs restarts the window timer, and `level_out` keeps its current value in that cycle.
- R10: Each accepted change produces exactly one one-cycle pulse in the same cycle as the new level: `rise_pulse` for 0 to 1 and `fall_pulse` for 1 to 0. No pulse is produced without a change.
- R11: Time advances only in cycles where `tick_en` is high. Without ticks, a filtered change is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle reference tick enable |
| pin_in | input | 1 | Raw asynchronous pin level |
| cfg_count | input | 4 | Window length in units (0 treated as 1) |
| cfg_large | input | 1 | High bit of the unit select |
| cfg_unit | input | 1 | Low bit of the unit select |
| cfg_mode | input | 2 | 0 bypass, 1 filter rises only, 2 filter falls only, 3 filter both |
| level_out | output | 1 | Filtered, registered level |
| rise_pulse | output | 1 | One-cycle pulse on an accepted rise |
| fall_pulse | output | 1 | One-cycle pulse on an accepted fall |

## Verification
The bench aligns each input change to the tick phase. It samples `level_out` two cycles before and a few cycles after the computed end of the window. A design off by a unit or by a count of one fails one side of that bracket, and so does a design that ignores the zero-count rule. Pulses a little shorter than the window are sent in mode 3. A design that does not restart on a return to the old level passes them, and so does one that keeps a stale count. In the one-sided modes the bench sends glitches in the unfiltered direction. A design that swaps the two one-sided modes either hides those glitches or accepts the filtered edge early. A configuration change is made mid-window. A design that keeps counting would switch near the old deadline, long before the checked point. A scoreboard matches every rise or fall pulse against the expected edge order, so missing, extra or stretched pulses are reported.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  localparam int DBF_CNT_W  = 4;
  localparam int DBF_TICK_W = 12;
  localparam int DBF_SEL_W  = 2;
  localparam int DBF_MODE_W = 2;

  typedef enum logic [DBF_MODE_W-1:0] {
    MODE_BYPASS    = 2'd0,
    MODE_KEEP_LOW  = 2'd1,
    MODE_KEEP_HIGH = 2'd2,
    MODE_BOTH      = 2'd3
  } dbf_mode_e;

  function automatic logic [DBF_TICK_W-1:0] dbf_unit_ticks(input logic [DBF_SEL_W-1:0] sel);
    logic [DBF_TICK_W-1:0] r;
    case (sel)
      2'b00:   r = DBF_TICK_W'(2);
      2'b01:   r = DBF_TICK_W'(8);
      2'b10:   r = DBF_TICK_W'(512);
      default: r = DBF_TICK_W'(2048);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbf_prescale.sv
module dbf_prescale
  import dbf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 tick_en,
  input  logic [DBF_SEL_W-1:0] sel,
  output logic                 unit_done
);
  logic [DBF_TICK_W-1:0] tick_cnt;
  logic [DBF_TICK_W-1:0] last;

  assign last      = dbf_unit_ticks(sel) - 1'b1;
  assign unit_done = run && tick_en && (tick_cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run)  tick_cnt <= '0;
    else if (tick_en) tick_cnt <= unit_done ? '0 : tick_cnt + 1'b1;
  end

  // R3: the tick counter never passes the selected unit length
  assert_tick_bound_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (tick_cnt <= last));
endmodule

// File: rtl/dbf_window.sv
module dbf_window
  import dbf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 unit_done,
  input  logic [DBF_CNT_W-1:0] count,
  output logic                 win_done
);
  logic [DBF_CNT_W-1:0] unit_cnt;
  logic [DBF_CNT_W-1:0] target;

  assign target   = (count == '0) ? DBF_CNT_W'(1) : count;
  assign win_done = unit_done && (unit_cnt == target - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run)    unit_cnt <= '0;
    else if (unit_done) unit_cnt <= win_done ? '0 : unit_cnt + 1'b1;
  end

  // R4: the unit counter stays inside the programmed window
  assert_unit_bound_R4: assert property (@(posedge clk) disable iff (rst)
    run |-> (unit_cnt < target));
endmodule

// File: rtl/dbf_debounce.sv
module dbf_debounce
  import dbf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_en,
  input  logic                  pin_in,
  input  logic [DBF_CNT_W-1:0]  cfg_count,
  input  logic                  cfg_large,
  input  logic                  cfg_unit,
  input  logic [DBF_MODE_W-1:0] cfg_mode,
  output logic                  level_out,
  output logic                  rise_pulse,
  output logic                  fall_pulse
);
  localparam int CFG_W = DBF_CNT_W + DBF_SEL_W + DBF_MODE_W;

  logic             sync_lvl;
  logic             filt_q, rise_q, fall_q;
  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             cfg_chg;
  dbf_mode_e        mode;
  logic             differs, filtered, run, accept;
  logic             unit_done, win_done;

  dbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_lvl)
  );

  assign cfg_now = {cfg_count, cfg_large, cfg_unit, cfg_mode};
  assign cfg_chg = (cfg_now != cfg_q);
  assign mode    = dbf_mode_e'(cfg_mode);
  assign differs = sync_lvl ^ filt_q;

  always_comb begin
    case (mode)
      MODE_BOTH:      filtered = 1'b1;
      MODE_KEEP_LOW:  filtered = sync_lvl;
      MODE_KEEP_HIGH: filtered = !sync_lvl;
      default:        filtered = 1'b0;
    endcase
  end

  assign run    = differs && filtered && !cfg_chg;
  assign accept = differs && !cfg_chg && (!filtered || win_done);

  dbf_prescale u_pre (
    .clk(clk), .rst(rst), .run(run), .tick_en(tick_en),
    .sel({cfg_large, cfg_unit}), .unit_done(unit_done)
  );

  dbf_window u_win (
    .clk(clk), .rst(rst), .run(run), .unit_done(unit_done),
    .count(cfg_count), .win_done(win_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      filt_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_now;
      rise_q <= accept && sync_lvl;
      fall_q <= accept && !sync_lvl;
      if (accept) filt_q <= sync_lvl;
    end
  end

  assign level_out  = filt_q;
  assign rise_pulse = rise_q;
  assign fall_pulse = fall_q;

  // R10: a level change is always marked by a pulse
  assert_change_pulsed_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> (rise_q || fall_q));

  // R9: a configuration change never moves the output
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> $stable(filt_q));

  // R2: bypass mode copies the synchronized level one cycle later
  assert_bypass_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_BYPASS && !cfg_chg) |=> (filt_q == $past(sync_lvl)));

  // R5: a filtered edge is taken only when the window timer completes
  assert_filtered_wait_R5: assert property (@(posedge clk) disable iff (rst)
    ((rise_q || fall_q) && $past(filtered)) |-> $past(win_done));
endmodule

// File: tb/dbf_debounce_tb.sv
module dbf_debounce_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       tick_en;
  logic       pin_in;
  logic [3:0] cfg_count;
  logic       cfg_large, cfg_unit;
  logic [1:0] cfg_mode;
  logic       level_out, rise_pulse, fall_pulse;

  int  total = 0;
  int  bad   = 0;
  int  tick_per = 4;
  bit  tick_off = 1'b0;
  int  pc = 0;
  bit  done = 1'b0;
  bit  exp_q[$];
  bit  prev_r = 1'b0, prev_f = 1'b0;

  always #2 clk = ~clk;

  dbf_debounce u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .pin_in(pin_in),
    .cfg_count(cfg_count), .cfg_large(cfg_large), .cfg_unit(cfg_unit),
    .cfg_mode(cfg_mode), .level_out(level_out),
    .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
  );

  always @(posedge clk) begin
    if (rst || tick_off) begin
      pc <= 0;
      tick_en <= 1'b0;
    end else begin
      tick_en <= (pc == tick_per - 1);
      pc <= (pc >= tick_per - 1) ? 0 : pc + 1;
    end
  end

  // monitor side of the scoreboard (R10)
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rise_pulse || fall_pulse) begin
        total++;
        if (rise_pulse && fall_pulse) begin
          bad++;
          $display("FAIL R10 both pulses rise=%0b fall=%0b expected one", rise_pulse, fall_pulse);
        end else if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R10 unexpected pulse rise=%0b fall=%0b expected none", rise_pulse, fall_pulse);
        end else begin
          bit e;
          e = exp_q.pop_front();
          if (e != rise_pulse) begin
            bad++;
            $display("FAIL R10 pulse kind rise=%0b expected rise=%0b", rise_pulse, e);
          end
        end
        if ((rise_pulse && prev_r) || (fall_pulse && prev_f)) begin
          total++;
          bad++;
          $display("FAIL R10 pulse longer than one cycle actual=2 expected=1");
        end
      end
      prev_r = rise_pulse;
      prev_f = fall_pulse;
    end
  end

  task automatic wait_pos(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic align();
    if (!tick_off) begin
      @(negedge clk);
      while (tick_en !== 1'b1) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk_lvl(input logic exp, input string req);
    total++;
    if (level_out !== exp) begin
      bad++;
      $display("FAIL %s level_out=%0b expected=%0b", req, level_out, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [3:0] c, input logic [1:0] sel);
    @(negedge clk);
    cfg_mode = m;
    cfg_count = c;
    {cfg_large, cfg_unit} = sel;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    pin_in = 1'b0;
    cfg_mode = 2'd0;
    cfg_count = 4'd0;
    {cfg_large, cfg_unit} = 2'b00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    wait_pos(2);
    // R1 reset state
    chk_lvl(1'b0, "R1");
    total++;
    if (rise_pulse || fall_pulse) begin
      bad++;
      $display("FAIL R1 pulses=%0b%0b expected=00", rise_pulse, fall_pulse);
    end

    // R2 bypass: three-edge latency, short pulse passes
    pin_in = 1'b1; exp_q.push_back(1'b1);
    wait_pos(2); chk_lvl(1'b0, "R2");
    wait_pos(2); chk_lvl(1'b1, "R2");
    pin_in = 1'b0; exp_q.push_back(1'b0);
    wait_pos(4); chk_lvl(1'b0, "R2");
    pin_in = 1'b1; exp_q.push_back(1'b1); exp_q.push_back(1'b0);
    @(negedge clk); pin_in = 1'b0;
    wait_pos(6);

    // R5 / R4 / R3: both directions, count 3, unit 2 ticks, tick every 4 cycles
    set_cfg(2'd3, 4'd3, 2'b00); wait_pos(4);
    align(); pin_in = 1'b1; exp_q.push_back(1'b1);
    wait_pos(22); chk_lvl(1'b0, "R5");
    wait_pos(6);  chk_lvl(1'b1, "R4");
    align(); pin_in = 1'b0; exp_q.push_back(1'b0);
    wait_pos(22); chk_lvl(1'b1, "R5");
    wait_pos(6);  chk_lvl(1'b0, "R5");

    // R5 glitch shorter than the window is removed
    align(); pin_in = 1'b1;
    wait_pos(16); pin_in = 1'b0;
    wait_pos(32); chk_lvl(1'b0, "R5");

    // R8 return to old level restarts the window
    align(); pin_in = 1'b1;
    wait_pos(16); pin_in = 1'b0;
    wait_pos(4);
    align(); pin_in = 1'b1; exp_q.push_back(1'b1);
    wait_pos(22); chk_lvl(1'b0, "R8");
    wait_pos(6);  chk_lvl(1'b1, "R8");

    // R6 mode 1: count 2, unit 8 ticks, tick every cycle
    tick_per = 1;
    set_cfg(2'd1, 4'd2, 2'b01); wait_pos(4);
    pin_in = 1'b0; exp_q.push_back(1'b0);
    wait_pos(4); chk_lvl(1'b0, "R6");
    pin_in = 1'b1; exp_q.push_back(1'b1);
    wait_pos(14); chk_lvl(1'b0, "R6");
    wait_pos(6);  chk_lvl(1'b1, "R6");
    pin_in = 1'b0; exp_q.push_back(1'b0); exp_q.push_back(1'b1);
    wait_pos(2); pin_in = 1'b1;
    wait_pos(2);  chk_lvl(1'b0, "R6");
    wait_pos(30); chk_lvl(1'b1, "R6");

    // R7 mode 2 with count 0 (one unit of 512 ticks)
    set_cfg(2'd2, 4'd0, 2'b10); wait_pos(4);
    chk_lvl(1'b1, "R9");
    pin_in = 1'b0; exp_q.push_back(1'b0);
    wait_pos(510); chk_lvl(1'b1, "R4");
    wait_pos(6);   chk_lvl(1'b0, "R7");
    pin_in = 1'b1; exp_q.push_back(1'b1);
    wait_pos(4); chk_lvl(1'b1, "R7");
    pin_in = 1'b0; exp_q.push_back(1'b0);
    wait_pos(520); chk_lvl(1'b0, "R7");
    pin_in = 1'b1; exp_q.push_back(1'b1); exp_q.push_back(1'b0);
    wait_pos(2); pin_in = 1'b0;
    wait_pos(2);   chk_lvl(1'b1, "R7");
    wait_pos(520); chk_lvl(1'b0, "R7");

    // R3 largest unit: count 2 of 2048 ticks
    set_cfg(2'd3, 4'd2, 2'b11); wait_pos(4);
    pin_in = 1'b1; exp_q.push_back(1'b1);
    wait_pos(4094); chk_lvl(1'b0, "R3");
    wait_pos(6);    chk_lvl(1'b1, "R3");

    // R9 configuration change mid-window restarts the timer
    tick_per = 4;
    set_cfg(2'd3, 4'd4, 2'b00); wait_pos(8);
    align(); pin_in = 1'b0; exp_q.push_back(1'b0);
    wait_pos(20); cfg_count = 4'd5;
    wait_pos(1);  chk_lvl(1'b1, "R9");
    wait_pos(37); chk_lvl(1'b1, "R9");
    wait_pos(6);  chk_lvl(1'b0, "R9");

    // R11 no ticks, no acceptance
    tick_off = 1'b1;
    @(negedge clk); pin_in = 1'b1;
    wait_pos(200); chk_lvl(1'b0, "R11");
    exp_q.push_back(1'b1);
    tick_off = 1'b0;
    wait_pos(60); chk_lvl(1'b1, "R11");

    wait_pos(4);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R10 missing pulses actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule